// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Two Postscaler

This block is a watchdog that runs on its own slow, free-running low-frequency clock. A fixed prescale divider turns that clock into a base tick: 128 clock periods, about 4 ms at the nominal frequency. A 16-bit postscaler counts base ticks. A 4-bit select code picks the postscaler ratio 2^code, so the timeout can be set anywhere from one base tick to 32,768 base ticks, roughly 4 ms to 131 s.

Software keeps the watchdog from expiring by issuing clear requests. Other events also restart the count: entering sleep, changing the oscillator frequency selection, a detected clock failure, and any device reset. These requests come from the fast system domain. Each one is resynchronised into the slow domain, and only its rising edge acts.

When the count expires, the block raises a one-cycle reset request, or a one-cycle wake-up request if the device is asleep. It also sets a sticky timeout flag. The watchdog runs whenever the hardware enable or the software enable is set. While the hardware enable is set, the software enable cannot turn it off.

Top module: `wdt_top`

## Requirements
- R1: With the watchdog running and no clear request, an expiry occurs every PRE_DIV * 2^sel cycles of `clk_lf` (PRE_DIV defaults to 128, and `ps_sel` = code 0..15 gives ratio 2^code). Both counters restart after each expiry, so expiries repeat at exactly that spacing.
- R2: Each expiry produces exactly one output pulse that is one `clk_lf` cycle wide. `wdt_reset` and `wdt_wake` are never high together.
- R3: A rising edge on `clr_instr` restarts the prescaler and the postscaler after a two-flop synchronizer and an edge detector. A request held high restarts them only once, so the next expiry still arrives one full period later.
- R4: A rising edge on any of `sleep_enter`, `osc_sel_chg`, `clk_fail` or `dev_rst` restarts both counters in the same way as `clr_instr`.
- R5: The watchdog runs when `hw_en | sw_en` is 1. With both enables at 0, both counters are held at zero and no pulse is produced. With `hw_en` at 1, the value of `sw_en` has no effect.
- R6: An expiry while the synchronized `asleep` input is 1 pulses `wdt_wake` and leaves `wdt_reset` low. An expiry while `asleep` is 0 pulses `wdt_reset` only.
- R7: `timeout_flag` is set by an expiry. Only a `clr_instr` edge or `por_n` clears it; the other clear requests leave it set.
- R8: While `por_n` is low, all counters, the synchronizers, both pulse outputs and `timeout_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf | input | 1 | Slow watchdog clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| hw_en | input | 1 | Hardware (configuration) enable |
| sw_en | input | 1 | Software enable |
| ps_sel | input | 4 | Postscaler select, ratio 2^ps_sel |
| clr_instr | input | 1 | Clear-watchdog request (fast domain) |
| sleep_enter | input | 1 | Sleep-entry request (fast domain) |
| osc_sel_chg | input | 1 | Oscillator frequency-select change request |
| clk_fail | input | 1 | Clock failure detected |
| dev_rst | input | 1 | Device reset event |
| asleep | input | 1 | Device is in a power-managed mode |
| wdt_reset | output | 1 | One-cycle reset request on expiry while awake |
| wdt_wake | output | 1 | One-cycle wake-up request on expiry while asleep |
| timeout_flag | output | 1 | Sticky expiry status |

## Verification
The bench measures the exact spacing between consecutive expiries for several select codes. An off-by-one in the tap mask or the prescale wrap would show up as a period one tick or one cycle too long or too short. It fires each of the five clear sources in mid-period and expects the next expiry to be pushed out. A source left out of the clear path would let the pulse arrive on the old schedule. It also holds `clr_instr` high for longer than a period: a level-sensitive clear would suppress expiry forever. Finally, it checks that only `clr_instr` erases the sticky flag, and that sleep steers the expiry to the wake-up output.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned WDT_PRE_DIV = 128;
  localparam int unsigned WDT_PS_W    = 16;
  localparam int unsigned WDT_SEL_W   = 4;
  localparam int unsigned WDT_NREQ    = 5;

  // bit positions of the clear-request vector
  typedef enum int unsigned {
    REQ_CLRWDT = 0,
    REQ_SLEEP  = 1,
    REQ_OSC    = 2,
    REQ_CFAIL  = 3,
    REQ_DEVRST = 4
  } wdt_req_e;

  // ticks needed = 2^sel; the low sel bits all-ones marks the last tick
  function automatic logic [31:0] tap_mask(input logic [4:0] sel);
    return (32'd1 << sel) - 32'd1;
  endfunction

  function automatic longint unsigned expiry_cycles(input int unsigned pre,
                                                    input int unsigned sel);
    return longint'(pre) << sel;
  endfunction

endpackage

// File: rtl/wdt_req_sync.sv
module wdt_req_sync #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_async,
  output logic [N-1:0] req_rise
);

  for (genvar i = 0; i < N; i++) begin : g_req
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= req_async[i];
        s2 <= s1;
        s3 <= s2;
      end
    end

    assign req_rise[i] = s2 & ~s3;

    // R3: a held request yields one edge only
    a_r3_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      req_rise[i] |=> !req_rise[i]);
  end

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int unsigned PRE_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick,
  output logic idle_zero
);

  localparam int unsigned CW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last   = (cnt == LAST);
  assign tick      = run & ~clr & at_last;
  assign idle_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || clr)    cnt <= '0;
    else if (at_last)        cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  if (PRE_DIV > 1) begin : g_spacing
    // R1: base ticks never come back to back when dividing
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end

  // R5: stopped divider stays at zero
  a_r5_prescale_held: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> idle_zero);

endmodule

// File: rtl/wdt_postscale.sv
module wdt_postscale
  import wdt_pkg::*;
#(
  parameter int unsigned PS_W  = WDT_PS_W,
  parameter int unsigned SEL_W = WDT_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             expire,
  output logic [PS_W-1:0]  count
);

  logic [31:0]     mask32;
  logic [PS_W-1:0] mask;

  assign mask32 = tap_mask(5'(sel));
  assign mask   = mask32[PS_W-1:0];
  assign expire = tick & ~clr & ((count & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       count <= '0;
    else if (!run || clr || expire)   count <= '0;
    else if (tick)                    count <= count + 1'b1;
  end

  // R1: each non-final tick advances the postscaler by one
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !expire) |=> count == $past(count) + 1'b1);

  // R1: counter restarts after an expiry
  a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count == '0);

endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned PRE_DIV = WDT_PRE_DIV,
  parameter int unsigned PS_W    = WDT_PS_W,
  parameter int unsigned SEL_W   = WDT_SEL_W
) (
  input  logic             clk_lf,
  input  logic             por_n,
  input  logic             hw_en,
  input  logic             sw_en,
  input  logic [SEL_W-1:0] ps_sel,
  input  logic             clr_instr,
  input  logic             sleep_enter,
  input  logic             osc_sel_chg,
  input  logic             clk_fail,
  input  logic             dev_rst,
  input  logic             asleep,
  output logic             wdt_reset,
  output logic             wdt_wake,
  output logic             timeout_flag
);

  logic [WDT_NREQ-1:0] req_vec;
  logic [WDT_NREQ-1:0] req_rise;
  logic                clr_any;
  logic                clr_soft;
  logic                run;
  logic                base_tick;
  logic                pre_zero;
  logic                expire;
  logic [PS_W-1:0]     post_cnt;
  logic                slp_s1, slp_s2;

  always_comb begin
    req_vec             = '0;
    req_vec[REQ_CLRWDT] = clr_instr;
    req_vec[REQ_SLEEP]  = sleep_enter;
    req_vec[REQ_OSC]    = osc_sel_chg;
    req_vec[REQ_CFAIL]  = clk_fail;
    req_vec[REQ_DEVRST] = dev_rst;
  end

  wdt_req_sync #(.N(WDT_NREQ)) u_sync (
    .clk       (clk_lf),
    .rst_n     (por_n),
    .req_async (req_vec),
    .req_rise  (req_rise)
  );

  assign clr_any  = |req_rise;
  assign clr_soft = req_rise[REQ_CLRWDT];
  // hardware enable overrides: software can only add, never remove
  assign run      = hw_en | sw_en;

  always_ff @(posedge clk_lf or negedge por_n) begin
    if (!por_n) begin
      slp_s1 <= 1'b0;
      slp_s2 <= 1'b0;
    end else begin
      slp_s1 <= asleep;
      slp_s2 <= slp_s1;
    end
  end

  wdt_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk       (clk_lf),
    .rst_n     (por_n),
    .run       (run),
    .clr       (clr_any),
    .tick      (base_tick),
    .idle_zero (pre_zero)
  );

  wdt_postscale #(.PS_W(PS_W), .SEL_W(SEL_W)) u_post (
    .clk    (clk_lf),
    .rst_n  (por_n),
    .run    (run),
    .clr    (clr_any),
    .tick   (base_tick),
    .sel    (ps_sel),
    .expire (expire),
    .count  (post_cnt)
  );

  always_ff @(posedge clk_lf or negedge por_n) begin
    if (!por_n) begin
      wdt_reset    <= 1'b0;
      wdt_wake     <= 1'b0;
      timeout_flag <= 1'b0;
    end else begin
      wdt_reset <= expire & ~slp_s2;
      wdt_wake  <= expire &  slp_s2;
      if (clr_soft)    timeout_flag <= 1'b0;
      else if (expire) timeout_flag <= 1'b1;
    end
  end

  // R2: pulses are one cycle wide
  a_r2_single_pulse: assert property (@(posedge clk_lf) disable iff (!por_n)
    (wdt_reset || wdt_wake) |=> !(wdt_reset || wdt_wake));

  // R2: never both outputs at once
  a_r2_exclusive: assert property (@(posedge clk_lf) disable iff (!por_n)
    !(wdt_reset && wdt_wake));

  // R3 / R4: any clear edge leaves both counters at zero
  a_r3_clear_restarts: assert property (@(posedge clk_lf) disable iff (!por_n)
    clr_any |=> (post_cnt == '0) && pre_zero);

  // R5: disabled watchdog stays silent
  a_r5_idle_silent: assert property (@(posedge clk_lf) disable iff (!por_n)
    !run |=> !(wdt_reset || wdt_wake));

  // R6: sleeping expiry becomes a wake-up
  a_r6_sleep_wake: assert property (@(posedge clk_lf) disable iff (!por_n)
    (expire && slp_s2) |=> (wdt_wake && !wdt_reset));

  // R7: expiry sets the flag
  a_r7_flag_set: assert property (@(posedge clk_lf) disable iff (!por_n)
    expire |=> timeout_flag);

  // R7: flag only changes on expiry or a clear-instruction edge
  a_r7_flag_hold: assert property (@(posedge clk_lf) disable iff (!por_n)
    (!expire && !clr_soft) |=> timeout_flag == $past(timeout_flag));

endmodule

// File: tb/wdt_top_tb.sv
module wdt_top_tb;

  localparam int unsigned PRE = 4;

  logic       clk_lf = 1'b0;
  logic       por_n = 1'b0;
  logic       hw_en = 1'b1, sw_en = 1'b0;
  logic [3:0] ps_sel = 4'd0;
  logic       clr_instr = 0, sleep_enter = 0, osc_sel_chg = 0, clk_fail = 0, dev_rst = 0;
  logic       asleep = 0;
  logic       wdt_reset, wdt_wake, timeout_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_lf = ~clk_lf;

  wdt_top #(.PRE_DIV(PRE)) u_dut (
    .clk_lf, .por_n, .hw_en, .sw_en, .ps_sel, .clr_instr, .sleep_enter,
    .osc_sel_chg, .clk_fail, .dev_rst, .asleep, .wdt_reset, .wdt_wake, .timeout_flag
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count negedges until a pulse; n = maxc if none seen
  task automatic wait_pulse(input int maxc, output int n, output bit rst, output bit wk);
    n = 0; rst = 0; wk = 0;
    for (int k = 0; k < maxc; k++) begin
      @(negedge clk_lf);
      n++;
      if (wdt_reset || wdt_wake) begin
        rst = wdt_reset; wk = wdt_wake;
        break;
      end
    end
  endtask

  task automatic do_por();
    @(negedge clk_lf);
    por_n = 1'b0;
    @(negedge clk_lf);
    por_n = 1'b1;
  endtask

  task automatic t_reset_state();
    @(negedge clk_lf);
    por_n = 1'b0;
    @(negedge clk_lf);
    check("R8 reset wdt_reset", wdt_reset, 0);
    check("R8 reset wdt_wake", wdt_wake, 0);
    check("R8 reset flag", timeout_flag, 0);
    por_n = 1'b1;
  endtask

  task automatic t_period(input int sel);
    int n; bit r, w;
    ps_sel = 4'(sel);
    do_por();
    wait_pulse(4000, n, r, w);
    wait_pulse(4000, n, r, w);
    check($sformatf("R1 period sel=%0d", sel), n, PRE << sel);
    check("R6 awake gives reset", r, 1);
    @(negedge clk_lf);
    check("R2 pulse width", wdt_reset, 0);
  endtask

  task automatic fire(input int idx);
    case (idx)
      0: clr_instr = 1; 1: sleep_enter = 1; 2: osc_sel_chg = 1; 3: clk_fail = 1;
      default: dev_rst = 1;
    endcase
  endtask

  task automatic t_clear(input int idx, input string req);
    int n; bit r, w;
    ps_sel = 4'd3;          // period 32
    do_por();
    wait_pulse(200, n, r, w);
    repeat (16) @(negedge clk_lf);
    fire(idx);
    repeat (2) @(negedge clk_lf);
    {clr_instr, sleep_enter, osc_sel_chg, clk_fail, dev_rst} = '0;
    wait_pulse(200, n, r, w);
    n = n + 18;
    check({req, " clear delays expiry"}, (n > 40 && n < 60) ? 1 : 0, 1);
  endtask

  task automatic t_held_clear();
    int n; bit r, w;
    ps_sel = 4'd3;
    do_por();
    wait_pulse(200, n, r, w);
    clr_instr = 1;
    wait_pulse(200, n, r, w);
    check("R3 held clear acts once", (n > 32 && n < 45) ? 1 : 0, 1);
    clr_instr = 0;
  endtask

  task automatic t_enable();
    int n; bit r, w;
    ps_sel = 4'd2;          // period 16
    hw_en = 0; sw_en = 0;
    do_por();
    wait_pulse(200, n, r, w);
    check("R5 disabled no pulse", r | w, 0);
    check("R5 disabled flag", timeout_flag, 0);
    sw_en = 1;
    wait_pulse(200, n, r, w);
    wait_pulse(200, n, r, w);
    check("R5 software enable period", n, 16);
    hw_en = 1; sw_en = 0;
    do_por();
    wait_pulse(200, n, r, w);
    sw_en = 1;
    wait_pulse(200, n, r, w);
    sw_en = 0;
    check("R5 sw_en ignored under hw_en", n, 16);
  endtask

  task automatic t_sleep();
    int n; bit r, w;
    ps_sel = 4'd2;
    asleep = 1;
    do_por();
    repeat (3) @(negedge clk_lf);
    wait_pulse(200, n, r, w);
    wait_pulse(200, n, r, w);
    check("R6 sleep gives wake", w, 1);
    check("R6 sleep no reset", r, 0);
    check("R6 sleep period", n, 16);
    asleep = 0;
  endtask

  task automatic t_flag();
    int n; bit r, w;
    ps_sel = 4'd3;
    do_por();
    wait_pulse(200, n, r, w);
    check("R7 flag set", timeout_flag, 1);
    osc_sel_chg = 1;
    repeat (5) @(negedge clk_lf);
    osc_sel_chg = 0;
    check("R7 flag kept on oscillator clear", timeout_flag, 1);
    clr_instr = 1;
    repeat (5) @(negedge clk_lf);
    clr_instr = 0;
    check("R7 flag cleared by clear instruction", timeout_flag, 0);
    wait_pulse(200, n, r, w);
    check("R7 flag set again", timeout_flag, 1);
    do_por();
    check("R8 por clears flag", timeout_flag, 0);
  endtask

  initial begin
    t_reset_state();
    t_period(0);
    t_period(3);
    t_period(5);
    t_period(9);
    t_clear(0, "R3");
    t_clear(1, "R4 sleep");
    t_clear(2, "R4 osc");
    t_clear(3, "R4 cfail");
    t_clear(4, "R4 devrst");
    t_held_clear();
    t_enable();
    t_sleep();
    t_flag();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_lf);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule